// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the probe side of a two-wire serial debug link. A local agent hands it one command at a time: a register transfer (debug-port or access-port select, read or write, two-bit register address, 32-bit write word), a line-reset burst, or a run of idle clocks. The engine produces the serial clock by dividing the system clock. It drives the data line through separate value, enable and input signals, so the pad and its pull-up stay outside the block.

A transfer runs the eight-bit request, one released turnaround slot and the three-bit acknowledge. The data phase follows. A write gets one more turnaround, then 32 data bits and their parity driven by the host. A read takes 33 bits straight after the acknowledge and closes with a turnaround. A WAIT acknowledge makes the engine release the line for one slot and reissue the same request, up to a retry limit set with each command. A FAULT or any unknown code ends the transfer after that turnaround, with no data phase. `busy` frames each command and `done` pulses once when its results are valid.

Top module: `swdh_engine`

## Requirements
- R1: The request goes out over eight serial slots, first slot first: 1, port select (1 = access port), read flag (1 = read), address bit 0, address bit 1, even parity of those four bits, 0, 1. The host drives all eight slots.
- R2: The host releases the line (`swdio_oe`=0) in the slot after the request. It then samples three acknowledge slots into `rsp_ack`, first received bit in bit 0, so OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100.
- R3: On a write with OK, the host releases one slot, then drives 32 data bits least significant first and one even-parity bit. The command ends right after that (46 slots in total).
- R4: On a read with OK, the host keeps the line released for 33 slots right after the acknowledge and then for one more turnaround slot (46 in total). `rsp_rdata` holds the 32 bits received. `rsp_perr` is 1 exactly when the 33rd bit differs from the even parity of the word.
- R5: On WAIT the host releases one slot and resends the identical request, at most `retry_limit` times per command. A WAIT beyond that limit ends the command with `rsp_timeout`=1 and `rsp_ack`=WAIT. Each refused attempt takes 13 slots.
- R6: A FAULT or an unknown acknowledge ends the command after 13 slots, with no data phase, `rsp_ack` set to the received code and `rsp_timeout`=0.
- R7: A line-reset command (`cmd_op`=1) drives 50 slots high and then 2 slots low.
- R8: An idle command (`cmd_op`=2) drives 8 slots low.
- R9: `swclk` has a period of 2·HALF_DIV system clocks and rests low between commands. The data-line value and enable change only when `swclk` falls, never while it is high.
- R10: After reset `busy`=0, `done`=0, `swclk`=0 and the line is driven low. A command with `cmd_valid` is accepted only while `busy`=0, and `busy` rises on the next cycle. `done` is a single-cycle pulse that ends `busy`. A command presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 0 transfer, 1 line reset, 2 idle clocks |
| cmd_apndp | input | 1 | Port select: 0 debug port, 1 access port |
| cmd_rnw | input | 1 | 1 read, 0 write |
| cmd_addr | input | 2 | Register address bits |
| cmd_wdata | input | 32 | Write word |
| retry_limit | input | RETRY_W | Maximum reissues after WAIT |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_ack | output | 3 | Acknowledge, first received bit in bit 0 |
| rsp_rdata | output | 32 | Read word |
| rsp_perr | output | 1 | Read parity mismatch |
| rsp_timeout | output | 1 | WAIT retries exhausted |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data value driven by host |
| swdio_oe | output | 1 | Host drive enable |
| swdio_i | input | 1 | Data line as seen at the pad |

## Verification
Two things meet in the same turnaround slot: a WAIT acknowledge and the retry counter reaching its limit. That one slot decides between a reissue and a timeout. The bench provokes it with a limit of two, answering WAIT twice and then OK, and separately three times. It also uses a limit of zero with a single WAIT. In each case it judges the outcome from the total number of serial clocks, from the request bits of the last attempt and from `rsp_timeout`. A second collision is a command strobe that arrives mid-transfer. It must leave the running transfer's slot count unchanged and start nothing afterwards.

// File: rtl/swdh_pkg.sv
package swdh_pkg;

  typedef enum logic [1:0] {
    OP_XFER   = 2'd0,
    OP_LRESET = 2'd1,
    OP_IDLE   = 2'd2
  } swdh_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_TRNA, S_ACK, S_TRNB,
    S_WDATA, S_RDATA, S_TRNC, S_RSTHI, S_RSTLO, S_IDLECYC
  } swdh_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  function automatic logic req_parity(input logic ap, input logic rd,
                                      input logic [1:0] addr);
    return ap ^ rd ^ addr[0] ^ addr[1];
  endfunction

  // bit 0 leaves the host first
  function automatic logic [7:0] req_byte(input logic ap, input logic rd,
                                          input logic [1:0] addr);
    return {1'b1, 1'b0, req_parity(ap, rd, addr), addr[1], addr[0], rd, ap, 1'b1};
  endfunction

  function automatic logic word_parity(input logic [31:0] w);
    return ^w;
  endfunction

endpackage

// File: rtl/swdh_clkgen.sv
module swdh_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic sample_pt,
  output logic slot_end
);
  localparam int CNT_W = $clog2(2 * HALF_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * HALF_DIV - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(HALF_DIV);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // low half first: every slot opens on a falling edge
  assign swclk     = run && (cnt >= MID);
  assign sample_pt = run && (cnt == MID);
  assign slot_end  = run && (cnt == LAST);
endmodule

// File: rtl/swdh_retry.sv
module swdh_retry #(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [RETRY_W-1:0] limit,
  input  logic               bump,
  output logic               exhausted
);
  logic [RETRY_W-1:0] cnt, limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      limit_q <= '0;
    end else if (load) begin
      cnt     <= '0;
      limit_q <= limit;
    end else if (bump) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign exhausted = (cnt == limit_q);

  // R5: reissues never pass the limit latched with the command
  a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit_q);
endmodule

// File: rtl/swdh_seq.sv
module swdh_seq
  import swdh_pkg::*;
#(
  parameter int LR_HI  = 50,
  parameter int LR_LO  = 2,
  parameter int IDLE_N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic        cmd_apndp,
  input  logic        cmd_rnw,
  input  logic [1:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  input  logic        sample_pt,
  input  logic        slot_end,
  input  logic        swdio_i,
  input  logic        retry_exh,
  output logic        retry_load,
  output logic        retry_bump,
  output logic        busy,
  output logic        done,
  output logic        swdio_o,
  output logic        swdio_oe,
  output logic [2:0]  rsp_ack,
  output logic [31:0] rsp_rdata,
  output logic        rsp_perr,
  output logic        rsp_timeout
);
  localparam int MAXS = (LR_HI > 33) ? LR_HI : 33;
  localparam int BC_W = $clog2(MAXS + 1);
  localparam logic [BC_W-1:0] LAST_REQ  = BC_W'(7);
  localparam logic [BC_W-1:0] LAST_ACK  = BC_W'(2);
  localparam logic [BC_W-1:0] LAST_DATA = BC_W'(32);
  localparam logic [BC_W-1:0] LAST_HI   = BC_W'(LR_HI - 1);
  localparam logic [BC_W-1:0] LAST_LO   = BC_W'(LR_LO - 1);
  localparam logic [BC_W-1:0] LAST_IDL  = BC_W'(IDLE_N - 1);

  swdh_state_e     state;
  logic [BC_W-1:0] bitcnt;
  logic [7:0]      req_q;
  logic            rnw_q;
  logic [31:0]     wdata_q;
  logic [32:0]     shreg;
  logic [2:0]      ack_q;

  // named events for the checks and the retry counter
  logic accept, ack_is_ok, ack_is_wait, trnb_end;
  assign accept      = cmd_valid && (state == S_IDLE);
  assign ack_is_ok   = (ack_q == ACK_OK);
  assign ack_is_wait = (ack_q == ACK_WAIT);
  assign trnb_end    = slot_end && (state == S_TRNB);
  assign retry_load  = accept;
  assign retry_bump  = trnb_end && ack_is_wait && !retry_exh;
  assign busy        = (state != S_IDLE);

  always_comb begin
    swdio_oe = 1'b1;
    swdio_o  = 1'b0;
    case (state)
      S_REQ:   swdio_o = req_q[bitcnt[2:0]];
      S_WDATA: swdio_o = (bitcnt == LAST_DATA) ? word_parity(wdata_q)
                                               : wdata_q[bitcnt[4:0]];
      S_RSTHI: swdio_o = 1'b1;
      S_TRNA, S_ACK, S_TRNB, S_RDATA, S_TRNC: swdio_oe = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bitcnt      <= '0;
      req_q       <= '0;
      rnw_q       <= 1'b0;
      wdata_q     <= '0;
      shreg       <= '0;
      ack_q       <= '0;
      done        <= 1'b0;
      rsp_ack     <= '0;
      rsp_rdata   <= '0;
      rsp_perr    <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        bitcnt <= '0;
        case (swdh_op_e'(cmd_op))
          OP_XFER: begin
            state   <= S_REQ;
            req_q   <= req_byte(cmd_apndp, cmd_rnw, cmd_addr);
            rnw_q   <= cmd_rnw;
            wdata_q <= cmd_wdata;
          end
          OP_LRESET: state <= S_RSTHI;
          default:   state <= S_IDLECYC;
        endcase
      end
      if (sample_pt && state == S_ACK)   ack_q[bitcnt[1:0]] <= swdio_i;
      if (sample_pt && state == S_RDATA) shreg[bitcnt[5:0]] <= swdio_i;
      if (slot_end) begin
        bitcnt <= bitcnt + 1'b1;
        case (state)
          S_REQ: if (bitcnt == LAST_REQ) begin state <= S_TRNA; bitcnt <= '0; end
          S_TRNA: begin state <= S_ACK; bitcnt <= '0; end
          S_ACK: if (bitcnt == LAST_ACK) begin
            bitcnt <= '0;
            state  <= (ack_is_ok && rnw_q) ? S_RDATA : S_TRNB;
          end
          S_RDATA: if (bitcnt == LAST_DATA) begin state <= S_TRNC; bitcnt <= '0; end
          S_TRNC: begin
            state       <= S_IDLE;
            done        <= 1'b1;
            rsp_ack     <= ack_q;
            rsp_rdata   <= shreg[31:0];
            rsp_perr    <= word_parity(shreg[31:0]) ^ shreg[32];
            rsp_timeout <= 1'b0;
          end
          S_TRNB: begin
            bitcnt <= '0;
            if (ack_is_ok) state <= S_WDATA;
            else if (ack_is_wait && !retry_exh) state <= S_REQ;
            else begin
              state       <= S_IDLE;
              done        <= 1'b1;
              rsp_ack     <= ack_q;
              rsp_rdata   <= '0;
              rsp_perr    <= 1'b0;
              rsp_timeout <= ack_is_wait;
            end
          end
          S_WDATA: if (bitcnt == LAST_DATA) begin
            state       <= S_IDLE;
            done        <= 1'b1;
            rsp_ack     <= ack_q;
            rsp_perr    <= 1'b0;
            rsp_timeout <= 1'b0;
          end
          S_RSTHI: if (bitcnt == LAST_HI) begin state <= S_RSTLO; bitcnt <= '0; end
          S_RSTLO: if (bitcnt == LAST_LO) begin state <= S_IDLE; done <= 1'b1; end
          S_IDLECYC: if (bitcnt == LAST_IDL) begin state <= S_IDLE; done <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  // R10: completion is a single pulse that leaves the engine idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5, R6: a timeout is only ever reported together with a WAIT code
  a_r5_timeout_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_timeout) |-> (rsp_ack == ACK_WAIT));
endmodule

// File: rtl/swdh_engine.sv
module swdh_engine #(
  parameter int HALF_DIV = 2,
  parameter int RETRY_W  = 4,
  parameter int LR_HI    = 50,
  parameter int LR_LO    = 2,
  parameter int IDLE_N   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_apndp,
  input  logic               cmd_rnw,
  input  logic [1:0]         cmd_addr,
  input  logic [31:0]        cmd_wdata,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic               busy,
  output logic               done,
  output logic [2:0]         rsp_ack,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_perr,
  output logic               rsp_timeout,
  output logic               swclk,
  output logic               swdio_o,
  output logic               swdio_oe,
  input  logic               swdio_i
);
  logic sample_pt, slot_end, retry_exh, retry_load, retry_bump;

  swdh_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .swclk(swclk), .sample_pt(sample_pt), .slot_end(slot_end));

  swdh_retry #(.RETRY_W(RETRY_W)) u_retry (
    .clk(clk), .rst_n(rst_n), .load(retry_load), .limit(retry_limit),
    .bump(retry_bump), .exhausted(retry_exh));

  swdh_seq #(.LR_HI(LR_HI), .LR_LO(LR_LO), .IDLE_N(IDLE_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .sample_pt(sample_pt), .slot_end(slot_end),
    .swdio_i(swdio_i), .retry_exh(retry_exh), .retry_load(retry_load),
    .retry_bump(retry_bump), .busy(busy), .done(done),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .rsp_timeout(rsp_timeout));

  // R9: line value and enable hold while the serial clock is high
  a_r9_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> ($stable(swdio_o) && $stable(swdio_oe)));
  // R9, R10: the serial clock rests low whenever no command runs
  a_r10_clock_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk);
endmodule

// File: tb/test_swdh_engine.sv
module test_swdh_engine;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_apndp = 1'b0, cmd_rnw = 1'b0;
  logic [1:0]  cmd_addr = 2'd0;
  logic [31:0] cmd_wdata = '0;
  logic [3:0]  retry_limit = 4'd0;
  logic        busy, done, rsp_perr, rsp_timeout, swclk, swdio_o, swdio_oe;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        tgt_oe = 1'b0, tgt_o = 1'b0;
  logic        line;

  assign line = swdio_oe ? swdio_o : (tgt_oe ? tgt_o : 1'b1);

  swdh_engine i_swdh_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .retry_limit(retry_limit), .busy(busy),
    .done(done), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_perr(rsp_perr), .rsp_timeout(rsp_timeout), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(line));

  always #(CLK_P / 2) clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  int  slot_n = 0;
  logic rec_o [0:127];
  logic rec_oe [0:127];
  time t_rise = 0, period = 0;
  int  high_viol = 0;
  logic prev_clk = 1'b0, prev_o = 1'b0, prev_oe = 1'b1;

  always @(posedge swclk) begin
    if (slot_n < 128) begin
      rec_o[slot_n]  = swdio_o;
      rec_oe[slot_n] = swdio_oe;
    end
    slot_n = slot_n + 1;
    period = $time - t_rise;
    t_rise = $time;
  end

  always @(negedge clk) begin
    if (swclk && prev_clk && (swdio_o !== prev_o || swdio_oe !== prev_oe))
      high_viol = high_viol + 1;
    prev_clk = swclk; prev_o = swdio_o; prev_oe = swdio_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  function automatic logic [7:0] exp_req(input logic ap, input logic rd, input logic [1:0] a);
    logic [7:0] v;
    v[0] = 1'b1; v[1] = ap; v[2] = rd; v[3] = a[0]; v[4] = a[1];
    v[5] = ap ^ rd ^ a[0] ^ a[1]; v[6] = 1'b0; v[7] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] got_req(input int base);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = rec_o[base + i] & rec_oe[base + i];
    return v;
  endfunction

  task automatic issue(input logic [1:0] op, input logic ap, input logic rd,
                       input logic [1:0] a, input logic [31:0] wd, input logic [3:0] lim);
    slot_n = 0;
    @(negedge clk);
    cmd_op = op; cmd_apndp = ap; cmd_rnw = rd; cmd_addr = a;
    cmd_wdata = wd; retry_limit = lim; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  // target side of one attempt, entered at the start of slot 0
  task automatic tgt_attempt(input logic [2:0] ack, input logic rd,
                             input logic [31:0] data, input logic flip);
    repeat (9) @(negedge swclk);
    tgt_oe = 1'b1; tgt_o = ack[0];
    @(negedge swclk); tgt_o = ack[1];
    @(negedge swclk); tgt_o = ack[2];
    if (ack == 3'b001 && rd) begin
      for (int i = 0; i < 33; i++) begin
        @(negedge swclk);
        tgt_o = (i < 32) ? data[i] : ((^data) ^ flip);
      end
    end
    @(negedge swclk); tgt_oe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset swclk", swclk, 0);
    chk("R10 reset line", {swdio_oe, swdio_o}, 2'b10);
  endtask

  task automatic t_write(input logic ap, input logic [1:0] a, input logic [31:0] wd);
    logic [32:0] got;
    fork
      issue(2'd0, ap, 1'b0, a, wd, 4'd0);
      begin wait (busy); tgt_attempt(3'b001, 1'b0, 0, 1'b0); end
    join
    chk("R1 write request", got_req(0), exp_req(ap, 1'b0, a));
    chk("R2 release after park", rec_oe[8], 0);
    chk("R3 release after ack", rec_oe[12], 0);
    for (int i = 0; i < 33; i++) got[i] = rec_o[13 + i] & rec_oe[13 + i];
    chk("R3 write word and parity", got, {^wd, wd});
    chk("R3 write slot count", slot_n, 46);
    chk("R2 write ack", rsp_ack, 3'b001);
  endtask

  task automatic t_read(input logic ap, input logic [1:0] a, input logic [31:0] d, input logic flip);
    int drv;
    fork
      issue(2'd0, ap, 1'b1, a, 32'hFFFF_FFFF, 4'd0);
      begin wait (busy); tgt_attempt(3'b001, 1'b1, d, flip); end
    join
    drv = 0;
    for (int i = 8; i < 46; i++) if (i != 8 && i < 12) ; else drv += rec_oe[i];
    chk("R1 read request", got_req(0), exp_req(ap, 1'b1, a));
    chk("R4 host released during data and turnaround", drv, 0);
    chk("R4 read slot count", slot_n, 46);
    chk("R4 read data", rsp_rdata, d);
    chk("R4 parity flag", rsp_perr, flip);
  endtask

  task automatic t_refused(input logic [2:0] ack);
    fork
      issue(2'd0, 1'b1, 1'b1, 2'd1, 0, 4'd3);
      begin wait (busy); tgt_attempt(ack, 1'b1, 32'h1234_5678, 1'b0); end
    join
    chk("R6 refused slot count", slot_n, 13);
    chk("R6 refused ack code", rsp_ack, ack);
    chk("R6 refused no timeout", rsp_timeout, 0);
  endtask

  task automatic t_wait(input int n_wait, input logic [3:0] lim, input logic finish_ok);
    int exp_slots;
    fork
      issue(2'd0, 1'b0, 1'b0, 2'd2, 32'hC3C3_0F0F, lim);
      begin
        wait (busy);
        for (int k = 0; k < n_wait; k++) begin
          tgt_attempt(3'b010, 1'b0, 0, 1'b0);
          if (k < lim) @(negedge swclk);
        end
        if (finish_ok) tgt_attempt(3'b001, 1'b0, 0, 1'b0);
      end
    join
    exp_slots = finish_ok ? 13 * n_wait + 46 : 13 * n_wait;
    chk("R5 slots with retries", slot_n, exp_slots);
    chk("R5 timeout flag", rsp_timeout, !finish_ok);
    chk("R5 final ack", rsp_ack, finish_ok ? 3'b001 : 3'b010);
    chk("R5 reissued request", got_req(13 * (n_wait - 1)), exp_req(1'b0, 1'b0, 2'd2));
  endtask

  task automatic t_lreset();
    int ones, zeros;
    issue(2'd1, 0, 0, 0, 0, 0);
    ones = 0; zeros = 0;
    for (int i = 0; i < 50; i++) ones += (rec_oe[i] & rec_o[i]);
    for (int i = 50; i < 52; i++) zeros += (rec_oe[i] & !rec_o[i]);
    chk("R7 reset slot count", slot_n, 52);
    chk("R7 high slots", ones, 50);
    chk("R7 low slots", zeros, 2);
  endtask

  task automatic t_idle();
    int lows;
    issue(2'd2, 0, 0, 0, 0, 0);
    lows = 0;
    for (int i = 0; i < 8; i++) lows += (rec_oe[i] & !rec_o[i]);
    chk("R8 idle slot count", slot_n, 8);
    chk("R8 idle low slots", lows, 8);
  endtask

  task automatic t_busy_ignore();
    int stray;
    fork
      issue(2'd0, 1'b1, 1'b0, 2'd3, 32'h0000_0001, 4'd0);
      begin wait (busy); tgt_attempt(3'b001, 1'b0, 0, 1'b0); end
      begin
        repeat (30) @(negedge clk);
        cmd_op = 2'd1; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'd0;
      end
    join
    stray = 0;
    repeat (20) begin @(negedge clk); stray += busy; end
    chk("R10 strobe while busy ignored, slot count", slot_n, 46);
    chk("R10 strobe while busy ignored, nothing after", stray, 0);
    chk("R1 request kept", got_req(0), exp_req(1'b1, 1'b0, 2'd3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write(1'b0, 2'd1, 32'hA5C3_9617);
    chk("R9 swclk period", period, 2 * HALF * CLK_P);
    t_write(1'b1, 2'd3, 32'h0F00_FF01);
    t_read(1'b1, 2'd2, 32'hDEAD_BEEF, 1'b0);
    t_read(1'b0, 2'd0, 32'h8000_0003, 1'b1);
    t_refused(3'b100);
    t_refused(3'b111);
    t_wait(2, 4'd2, 1'b1);
    t_wait(3, 4'd2, 1'b0);
    t_wait(1, 4'd0, 1'b0);
    t_lreset();
    t_idle();
    t_busy_ignore();
    chk("R9 no change while clock high", high_viol, 0);
    chk("R9 clock rests low", swclk, 0);
    summary();
  end
endmodule